// File: doc/BRIEF.md
# Storage Idle Timer with System-Management Interrupt

This block tracks how long a storage device has gone without traffic on its data port and asks for a system-management interrupt (SMI) once that quiet period reaches a programmed number of seconds. Power-management firmware uses the interrupt to spin the device down. The block watches decoded I/O cycles on a snoop input. Any strobed access to the selected data port, at 1F0h or 170h, restarts the countdown from the programmed value. A free-running one-second tick from elsewhere in the chip is the timebase.

Software talks to the block through a small register interface with four registers:

| Select | Register | Access |
|---|---|---|
| 0 | 16-bit reload value | read/write |
| 1 | Control | read/write |
| 2 | Timer-specific status | read clears; write-one clears |
| 3 | Top-level SMI summary | read only |

When the count runs out, the block sets the timer-specific status bit and the top-level summary, and raises the SMI request. The counter then rests until the device is touched again, so each idle episode gives exactly one interrupt.

Top module: `disk_idle_smi`

## Requirements
- R1: After a synchronous reset, the reload value, control, both status bits, `rd_data` and `smi_req` are all zero.
- R2: Select 0 holds a 16-bit reload value. A write stores `wr_data`. A read returns the stored value on `rd_data` one cycle after `rd_en` is sampled.
- R3: Select 1 is control. Bit 0 enables the timer. Bit 1 picks the port: 0 selects 1F0h and 1 selects 170h. Both bits read back in place, and the upper bits read as zero.
- R4: With the timer enabled and a nonzero reload value N, the N-th tick after the last reload event sets the status at that clock edge. The first cycle after that tick shows `smi_req` high.
- R5: A cycle with `snoop_stb` high and `snoop_addr` equal to the selected port reloads the counter. Either port address with the strobe low, or the other port's address, has no effect on the count.
- R6: While bit 0 of control is 0, ticks are ignored and the counter is held at the reload value.
- R7: A write to select 0 while the timer is enabled restarts the countdown from the newly written value and cancels a pending expiry.
- R8: With a reload value of zero the timer never expires.
- R9: After an expiry the counter stays stopped, with no further expiry, until the next matching port access. Counting then restarts from the reload value.
- R10: Select 2 bit 0 is the timer's status. A read returns it and clears it. Writing 1 to bit 0 clears it, and writing 0 leaves it unchanged.
- R11: Select 3 bit 0 and `smi_req` are high exactly while a timer-specific status bit is set. Reading select 3 does not clear anything.
- R12: An expiry in the same cycle as a status clear leaves the status set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| snoop_stb | input | 1 | Qualifies an observed I/O access |
| snoop_addr | input | 16 | Decoded I/O address of the observed access |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Registered read data |
| smi_req | output | 1 | SMI request, level, held while status is set |

## Verification
The bench aims at the exact tick on which expiry lands. A design that was off by one would raise `smi_req` a second early or late.

It also tests these corner cases:
- **Same-cycle collisions.** A tick coincides with a port access, and an expiry coincides with a status read. A wrong priority would drop the reload or lose the interrupt.
- **Unselected port address.** An access to the other port, or with the strobe low, must not restart the timer. A sloppy address compare would keep the device awake forever.
- **Reload value of zero.** This must never fire.
- **Rest after expiry.** A counter that wrapped instead of resting would fire again every N seconds without any disk traffic.

// File: rtl/dis_pkg.sv
package dis_pkg;
  typedef enum logic [1:0] {
    SEL_RELOAD   = 2'd0,
    SEL_CTRL     = 2'd1,
    SEL_SRC_STAT = 2'd2,
    SEL_TOP_STAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_PORT_BIT = 1;
  localparam int STAT_IDLE_BIT = 0;
endpackage

// File: rtl/dis_port_match.sv
module dis_port_match #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] PORT_A = 16'h01F0,
  parameter logic [15:0] PORT_B = 16'h0170
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              stb,
  input  logic              port_sel,
  output logic              hit
);
  localparam int NPORT = 2;
  logic [NPORT-1:0] match;

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam logic [ADDR_W-1:0] PADDR = (i == 0) ? ADDR_W'(PORT_A) : ADDR_W'(PORT_B);
    assign match[i] = (addr == PADDR);
  end

  assign hit = stb && match[port_sel];
endmodule

// File: rtl/dis_idle_cnt.sv
module dis_idle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ld_wr,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             hit,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic live;
  assign live   = en && !ld_wr && !hit && tick && !done_q && (reload_val != '0);
  assign expire = live && (cnt_q <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!en) begin
      cnt_q  <= reload_val;
      done_q <= 1'b0;
    end else if (ld_wr) begin
      cnt_q  <= ld_data;
      done_q <= 1'b0;
    end else if (hit) begin
      cnt_q  <= reload_val;
      done_q <= 1'b0;
    end else if (expire) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (live) begin
      cnt_q  <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/dis_stat.sv
module dis_stat #(
  parameter int NSRC = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] src_q,
  output logic            top_q
);
  logic [NSRC-1:0] src_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign src_d[i] = set[i] | (src_q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) src_q[i] <= 1'b0;
      else     src_q[i] <= src_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) top_q <= 1'b0;
    else     top_q <= |src_d;
  end
endmodule

// File: rtl/disk_idle_smi.sv
module disk_idle_smi #(
  parameter int          CNT_W  = 16,
  parameter int          ADDR_W = 16,
  parameter logic [15:0] PORT_A = 16'h01F0,
  parameter logic [15:0] PORT_B = 16'h0170
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1s,
  input  logic              snoop_stb,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_sel,
  output logic [CNT_W-1:0]  rd_data,
  output logic              smi_req
);
  import dis_pkg::*;

  localparam int NSRC = 1;

  logic [CNT_W-1:0] reload_q;
  logic             en_q;
  logic             psel_q;
  logic             hit;
  logic             ld_wr;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             expire;
  logic [NSRC-1:0]  sl_q;
  logic [NSRC-1:0]  sl_clr;
  logic             top_q;
  logic             wr_rel;
  logic             wr_ctl;
  logic             wr_sst;
  logic             rd_sst;

  assign wr_rel = wr_en && (reg_sel_e'(wr_sel) == SEL_RELOAD);
  assign wr_ctl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign wr_sst = wr_en && (reg_sel_e'(wr_sel) == SEL_SRC_STAT);
  assign rd_sst = rd_en && (reg_sel_e'(rd_sel) == SEL_SRC_STAT);
  assign ld_wr  = wr_rel;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      en_q     <= 1'b0;
      psel_q   <= 1'b0;
    end else begin
      if (wr_rel) reload_q <= wr_data;
      if (wr_ctl) begin
        en_q   <= wr_data[CTRL_EN_BIT];
        psel_q <= wr_data[CTRL_PORT_BIT];
      end
    end
  end

  dis_port_match #(.ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B)) u_match (
    .addr(snoop_addr), .stb(snoop_stb), .port_sel(psel_q), .hit(hit)
  );

  dis_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .reload_val(reload_q),
    .ld_wr(ld_wr), .ld_data(wr_data), .hit(hit), .tick(tick_1s),
    .cnt_q(cnt_q), .done_q(done_q), .expire(expire)
  );

  assign sl_clr = {NSRC{rd_sst | (wr_sst & wr_data[STAT_IDLE_BIT])}};

  dis_stat #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst(rst), .set(expire), .clr(sl_clr), .src_q(sl_q), .top_q(top_q)
  );

  assign smi_req = top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      case (reg_sel_e'(rd_sel))
        SEL_RELOAD:   rd_data <= reload_q;
        SEL_CTRL:     rd_data <= {{(CNT_W-2){1'b0}}, psel_q, en_q};
        SEL_SRC_STAT: rd_data <= {{(CNT_W-NSRC){1'b0}}, sl_q};
        default:      rd_data <= {{(CNT_W-1){1'b0}}, top_q};
      endcase
    end
  end
endmodule

// File: rtl/dis_chk.sv
module dis_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_1s,
  input logic             smi_req,
  input logic             en_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             done_q,
  input logic [0:0]       sl_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!smi_req && sl_q == 1'b0));

  // R4
  rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(smi_req) |-> $past(tick_1s && en_q));

  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> (cnt_q == $past(reload_q)));

  // R8
  zero_never_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_q == '0) |=> !$rose(sl_q[0]));

  // R9
  rest_after_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cnt_q == '0));

  // R11
  top_mirrors_src_chk: assert property (@(posedge clk) disable iff (rst)
    smi_req == sl_q[0]);
endmodule

bind disk_idle_smi dis_chk u_chk (
  .clk(clk), .rst(rst), .tick_1s(tick_1s), .smi_req(smi_req), .en_q(en_q),
  .reload_q(reload_q), .cnt_q(cnt_q), .done_q(done_q), .sl_q(sl_q)
);

// File: tb/sim_disk_idle_smi.sv
`timescale 1ns/1ps
module sim_disk_idle_smi;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1s = 1'b0;
  logic        snoop_stb = 1'b0;
  logic [15:0] snoop_addr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        smi_req;

  int checks = 0;
  int failures = 0;

  // bench model of the register-visible state
  logic [15:0] m_reload = '0, m_cnt = '0, m_rd = '0;
  logic        m_en = 0, m_psel = 0, m_done = 0, m_sl = 0;

  always #10 clk = ~clk;

  disk_idle_smi u0 (.*);

  function automatic logic [15:0] port_of(input logic psel);
    return psel ? 16'h0170 : 16'h01F0;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic tk, input logic stb, input logic [15:0] addr,
                      input logic wr, input logic [1:0] ws, input logic [15:0] wd,
                      input logic rd, input logic [1:0] rs);
    logic hit, ex, clr;
    tick_1s = tk; snoop_stb = stb; snoop_addr = addr;
    wr_en = wr; wr_sel = ws; wr_data = wd; rd_en = rd; rd_sel = rs;
    hit = stb && (addr == port_of(m_psel));
    ex = 1'b0;
    if (rd) begin
      case (rs)
        2'd0: m_rd = m_reload;
        2'd1: m_rd = {14'd0, m_psel, m_en};
        2'd2: m_rd = {15'd0, m_sl};
        default: m_rd = {15'd0, m_sl};
      endcase
    end
    if (!m_en) begin m_cnt = m_reload; m_done = 0; end
    else if (wr && ws == 2'd0) begin m_cnt = wd; m_done = 0; end
    else if (hit) begin m_cnt = m_reload; m_done = 0; end
    else if (tk && !m_done && m_reload != 0) begin
      if (m_cnt <= 1) begin ex = 1; m_cnt = 0; m_done = 1; end
      else m_cnt = m_cnt - 1;
    end
    clr = (rd && rs == 2'd2) || (wr && ws == 2'd2 && wd[0]);
    m_sl = ex ? 1'b1 : (clr ? 1'b0 : m_sl);
    if (wr && ws == 2'd0) m_reload = wd;
    if (wr && ws == 2'd1) begin m_en = wd[0]; m_psel = wd[1]; end
    @(posedge clk); #1;
    check(req, {15'd0, smi_req}, {15'd0, m_sl});
    if (rd) check(req, rd_data, m_rd);
    tick_1s = 0; snoop_stb = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic idle(input string req, input logic tk);
    step(req, tk, 0, 16'h0, 0, 0, 0, 0, 0);
  endtask
  task automatic wreg(input string req, input logic [1:0] s, input logic [15:0] d);
    step(req, 0, 0, 16'h0, 1, s, d, 0, 0);
  endtask
  task automatic rreg(input string req, input logic [1:0] s);
    step(req, 0, 0, 16'h0, 0, 0, 0, 1, s);
  endtask
  task automatic touch(input string req, input logic [15:0] a);
    step(req, 0, 1, a, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset values
    check("R1 smi", {15'd0, smi_req}, 16'd0);
    check("R1 rd_data", rd_data, 16'd0);
    for (int s = 0; s < 4; s++) rreg("R1", 2'(s));
    // R2 / R3 register access
    wreg("R2", 2'd0, 16'h1234); rreg("R2", 2'd0);
    wreg("R3", 2'd1, 16'hFFFE); rreg("R3", 2'd1);
    // R6 disabled: ticks ignored
    wreg("R6", 2'd0, 16'd2); wreg("R6", 2'd1, 16'h0000);
    for (int i = 0; i < 5; i++) idle("R6", 1);
    // R4 expiry after N ticks, R5 port 1F0h
    wreg("R4", 2'd0, 16'd3); wreg("R4", 2'd1, 16'h0001);
    touch("R5", 16'h01F0);
    idle("R4", 1); idle("R4", 1); idle("R4", 0);
    step("R5 tick with access", 1, 1, 16'h01F0, 0, 0, 0, 0, 0);
    idle("R4", 1); idle("R4", 1); idle("R4", 1);
    check("R4 smi high", {15'd0, smi_req}, 16'd1);
    // R9 no refire while resting
    for (int i = 0; i < 6; i++) idle("R9", 1);
    // R11 top read does not clear
    rreg("R11", 2'd3); rreg("R11", 2'd3);
    // R10 write 0 no effect, read clears
    wreg("R10 write0", 2'd2, 16'h0000);
    rreg("R10", 2'd2); rreg("R10", 2'd2);
    check("R10 cleared", {15'd0, smi_req}, 16'd0);
    // R9 access restarts counting
    touch("R9", 16'h01F0);
    for (int i = 0; i < 3; i++) idle("R9", 1);
    check("R9 refired", {15'd0, smi_req}, 16'd1);
    wreg("R10 write1", 2'd2, 16'h0001);
    // R5 port 170h, other address and strobe-low ignored
    wreg("R5", 2'd1, 16'h0003);
    touch("R5", 16'h0170);
    idle("R5", 1); idle("R5", 1);
    touch("R5 wrong port", 16'h01F0);
    step("R5 strobe low", 0, 0, 16'h0170, 0, 0, 0, 0, 0);
    idle("R5", 1);
    check("R5 expired despite non-hits", {15'd0, smi_req}, 16'd1);
    rreg("R10", 2'd2);
    // R7 reload write restarts
    touch("R7", 16'h0170);
    idle("R7", 1); idle("R7", 1);
    wreg("R7", 2'd0, 16'd4);
    for (int i = 0; i < 3; i++) idle("R7", 1);
    check("R7 not yet", {15'd0, smi_req}, 16'd0);
    idle("R7", 1);
    check("R7 fired", {15'd0, smi_req}, 16'd1);
    // R12 expiry coincident with clear
    rreg("R12", 2'd2);
    wreg("R12", 2'd0, 16'd1); touch("R12", 16'h0170);
    step("R12 tick+read", 1, 0, 16'h0, 0, 0, 0, 1, 2'd2);
    check("R12 set wins", {15'd0, smi_req}, 16'd1);
    rreg("R12", 2'd2);
    // R8 reload zero never expires
    wreg("R8", 2'd0, 16'd0); touch("R8", 16'h0170);
    for (int i = 0; i < 10; i++) idle("R8", 1);
    check("R8 silent", {15'd0, smi_req}, 16'd0);
    // randomized mix
    void'($urandom(32'd7));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      logic [15:0] a = $urandom_range(0, 1) ? 16'h01F0 : 16'h0170;
      if (r < 3)       wreg("R2 rand", 2'd0, 16'($urandom_range(0, 6)));
      else if (r < 5)  wreg("R3 rand", 2'd1, 16'($urandom_range(0, 3)));
      else if (r < 8)  rreg("R10 rand", 2'($urandom_range(0, 3)));
      else if (r < 9)  wreg("R10 rand", 2'd2, 16'($urandom_range(0, 1)));
      else step("R4 rand", 1'($urandom_range(0, 1)), r < 20, a, 0, 0, 0, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule